// File: doc/BRIEF.md
# Trapping Integer Execute Unit with Shifter

This block is the integer execute stage of a 32-bit RISC core. Each accepted operation takes two 32-bit operands, a 4-bit operation code and a 5-bit immediate shift amount. It returns a result that is sign-extended to 64 bits, a write-enable and an overflow-trap strobe. The operations are wrapping and trapping add and subtract, left and right logical shifts, arithmetic right shift, right rotate, and leading-zero and leading-one counts. Each shift and rotate takes its amount either from the immediate or from a register operand.

The arithmetic is combinational. One output register stage sits behind it, with a valid/ready handshake on both sides. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` from the next cycle on. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the stage holds its contents and `in_ready` is low. This back-pressure reaches the producer in the same cycle. The block does not vector exceptions: it only raises the strobe and suppresses the write.

Top module: `trap_alu_exec`

## Requirements
- R1: Codes 0 (add) and 1 (subtract, `src_a - src_b`) wrap modulo 2^32 and never assert `out_ovf_trap`.
- R2: Code 2 (trapping add) gives `src_a + src_b` and asserts `out_ovf_trap` exactly when both operands have the same sign and the 32-bit sum's sign differs from it.
- R3: Code 3 (trapping subtract) gives `src_a - src_b` and asserts `out_ovf_trap` exactly when the operand signs differ and the result's sign differs from the sign of `src_a`.
- R4: `out_wr_en` is low whenever `out_ovf_trap` is high, and high for every other accepted operation.
- R5: Bits 63:32 of `out_result` always equal copies of bit 31, for every operation, shifts included.
- R6: Codes 4, 5 and 6 shift `src_a` left logically, right logically and right arithmetically by `shamt`. Codes 8, 9 and 10 do the same by `src_b[4:0]`, and the upper bits of `src_b` are ignored.
- R7: Codes 7 (amount from `shamt`) and 11 (amount from `src_b[4:0]`) rotate `src_a` right. An amount of zero returns `src_a` unchanged.
- R8: Code 12 counts the leading zeros of `src_a` and code 13 counts its leading ones, scanning from bit 31 down. Each returns 32 when no bit ends the run.
- R9: Codes 14 and 15 produce a zero result with no trap and `out_wr_en` high.
- R10: A result appears with `out_valid` in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold steady.
- R11: During and just after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| op | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | First operand; value shifted, rotated or counted |
| src_b | input | 32 | Second operand; register shift amount in bits 4:0 |
| shamt | input | 5 | Immediate shift or rotate amount |
| out_valid | output | 1 | Result stage holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Sign-extended 32-bit result |
| out_wr_en | output | 1 | Destination register may be written |
| out_ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |

## Verification
Every result, trap strobe and write-enable is due exactly one rising edge after the edge that accepts the operation. The bench drives inputs on the falling edge, waits for one rising edge, and compares all three outputs on the next falling edge. In the stall sequence, the outputs are compared on several successive falling edges with `out_ready` held low, and a second operation offered during the stall is checked to appear only one edge after `out_ready` returns high.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_WRAP = 4'd0,
    OP_SUB_WRAP = 4'd1,
    OP_ADD_TRAP = 4'd2,
    OP_SUB_TRAP = 4'd3,
    OP_SLL_IMM  = 4'd4,
    OP_SRL_IMM  = 4'd5,
    OP_SRA_IMM  = 4'd6,
    OP_ROR_IMM  = 4'd7,
    OP_SLL_REG  = 4'd8,
    OP_SRL_REG  = 4'd9,
    OP_SRA_REG  = 4'd10,
    OP_ROR_REG  = 4'd11,
    OP_CNT_ZERO = 4'd12,
    OP_CNT_ONE  = 4'd13
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2,
    SH_ROT   = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    SEL_ARITH = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_ZERO  = 2'd3
  } res_sel_e;

  typedef struct packed {
    logic        subtract;
    logic        trap_en;
    logic        amt_from_reg;
    logic        count_ones;
    shift_kind_e kind;
    res_sel_e    sel;
  } alu_ctl_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  input  logic         trap_en,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic sa, sb, sr;

  always_comb begin
    sum = subtract ? (a - b) : (a + b);
    sa  = a[W-1];
    sb  = b[W-1];
    sr  = sum[W-1];
    if (subtract) ovf = trap_en && (sa != sb) && (sr != sa);
    else          ovf = trap_en && (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import trap_alu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [AW-1:0] amt,
  input  shift_kind_e   kind,
  output logic [W-1:0]  res
);
  localparam logic [AW:0] W_VAL = (AW+1)'(W);

  logic [AW:0]  back_amt;
  logic [W-1:0] rot;

  always_comb begin
    back_amt = W_VAL - {1'b0, amt};
    // a zero amount must not turn into a shift by the full width
    if (amt == '0) rot = val;
    else           rot = (val >> amt) | (val << back_amt);
  end

  always_comb begin
    unique case (kind)
      SH_LEFT: res = val << amt;
      SH_RLOG: res = val >> amt;
      SH_RARI: res = W'($signed(val) >>> amt);
      default: res = rot;
    endcase
  end
endmodule

// File: rtl/alu_lead_count.sv
module alu_lead_count #(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  input  logic          ones,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] scan;
  logic         found;

  always_comb begin
    scan  = ones ? ~val : val;
    cnt   = CW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && scan[i]) begin
        cnt   = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_alu_exec.sv
module trap_alu_exec
  import trap_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned OLEN = 64,
  parameter int unsigned AW   = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [AW-1:0]   shamt,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OLEN-1:0] out_result,
  output logic            out_wr_en,
  output logic            out_ovf_trap
);
  localparam int unsigned CW  = AW + 1;
  localparam int unsigned EXT = OLEN - XLEN;

  alu_ctl_t        ctl;
  logic [XLEN-1:0] arith_res, shift_res, word_res;
  logic [AW-1:0]   amt;
  logic [CW-1:0]   cnt_res;
  logic            ovf;
  logic            accept;

  // operation decode
  always_comb begin
    ctl = '{subtract: 1'b0, trap_en: 1'b0, amt_from_reg: 1'b0,
            count_ones: 1'b0, kind: SH_LEFT, sel: SEL_ZERO};
    case (op)
      OP_ADD_WRAP: ctl.sel = SEL_ARITH;
      OP_SUB_WRAP: begin ctl.sel = SEL_ARITH; ctl.subtract = 1'b1; end
      OP_ADD_TRAP: begin ctl.sel = SEL_ARITH; ctl.trap_en = 1'b1; end
      OP_SUB_TRAP: begin ctl.sel = SEL_ARITH; ctl.subtract = 1'b1; ctl.trap_en = 1'b1; end
      OP_SLL_IMM, OP_SRL_IMM, OP_SRA_IMM, OP_ROR_IMM,
      OP_SLL_REG, OP_SRL_REG, OP_SRA_REG, OP_ROR_REG: begin
        ctl.sel          = SEL_SHIFT;
        ctl.amt_from_reg = op[3];
        ctl.kind         = shift_kind_e'(op[1:0]);
      end
      OP_CNT_ZERO: ctl.sel = SEL_COUNT;
      OP_CNT_ONE:  begin ctl.sel = SEL_COUNT; ctl.count_ones = 1'b1; end
      default:     ctl.sel = SEL_ZERO;
    endcase
  end

  assign amt = ctl.amt_from_reg ? src_b[AW-1:0] : shamt;

  alu_addsub #(.W(XLEN)) u_addsub (
    .a(src_a), .b(src_b), .subtract(ctl.subtract), .trap_en(ctl.trap_en),
    .sum(arith_res), .ovf(ovf)
  );

  alu_shifter #(.W(XLEN), .AW(AW)) u_shift (
    .val(src_a), .amt(amt), .kind(ctl.kind), .res(shift_res)
  );

  alu_lead_count #(.W(XLEN), .CW(CW)) u_count (
    .val(src_a), .ones(ctl.count_ones), .cnt(cnt_res)
  );

  always_comb begin
    unique case (ctl.sel)
      SEL_ARITH: word_res = arith_res;
      SEL_SHIFT: word_res = shift_res;
      SEL_COUNT: word_res = XLEN'(cnt_res);
      default:   word_res = '0;
    endcase
  end

  // single output register stage with valid/ready
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_wr_en    <= 1'b0;
      out_ovf_trap <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= {{EXT{word_res[XLEN-1]}}, word_res};
        out_ovf_trap <= ovf;
        out_wr_en    <= !ovf;
      end
    end
  end

  AST_WRAP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_ADD_WRAP || op == OP_SUB_WRAP) |=> !out_ovf_trap) // R1
    else $error("wrapping op trapped");

  AST_ADD_OVF_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_ADD_TRAP && src_a[XLEN-1] == src_b[XLEN-1]
      && arith_res[XLEN-1] != src_a[XLEN-1] |=> out_ovf_trap) // R2
    else $error("add overflow missed");

  AST_SUB_OVF_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_SUB_TRAP && src_a[XLEN-1] != src_b[XLEN-1]
      && arith_res[XLEN-1] != src_a[XLEN-1] |=> out_ovf_trap) // R3
    else $error("sub overflow missed");

  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf_trap |-> !out_wr_en) // R4
    else $error("write enabled on trap");

  AST_SIGN_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result[OLEN-1:XLEN] == {EXT{out_result[XLEN-1]}}) // R5
    else $error("upper bits not sign copies");

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_CNT_ZERO || op == OP_CNT_ONE) |=> out_result <= OLEN'(XLEN)) // R8
    else $error("count exceeds width");

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op[3:1] == 3'b111 |=> out_result == '0 && !out_ovf_trap && out_wr_en) // R9
    else $error("unused code not zero");

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_ovf_trap) && $stable(out_wr_en)) // R10
    else $error("output changed under stall");

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid) // R10
    else $error("accepted op not presented");
endmodule

// File: tb/tb_trap_alu_exec.sv
module tb_trap_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [4:0]  shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_wr_en, out_ovf_trap;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  trap_alu_exec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .src_a(src_a), .src_b(src_b), .shamt(shamt),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_ovf_trap(out_ovf_trap)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1:                          return "R1";
      4'd2:                                return "R2";
      4'd3:                                return "R3";
      4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10: return "R6";
      4'd7, 4'd11:                         return "R7";
      4'd12, 4'd13:                        return "R8";
      default:                             return "R9";
    endcase
  endfunction

  function automatic int lead_run(input logic [31:0] v, input logic bitv);
    int n = 0;
    while (n < 32 && v[31-n] == bitv) n++;
    return n;
  endfunction

  // reference: 32-bit result and trap flag
  function automatic void model(input logic [3:0] c, input logic [31:0] a,
                                input logic [31:0] b, input logic [4:0] s,
                                output logic [31:0] r, output logic trap);
    logic signed [32:0] wide;
    logic [63:0]        dbl;
    logic [4:0]         n;
    trap = 1'b0;
    n    = c[3] ? b[4:0] : s;
    dbl  = {a, a} >> n;
    case (c)
      4'd0, 4'd2: begin
        wide = $signed({a[31], a}) + $signed({b[31], b});
        r = wide[31:0];
        trap = (c == 4'd2) && (wide[32] != wide[31]);
      end
      4'd1, 4'd3: begin
        wide = $signed({a[31], a}) - $signed({b[31], b});
        r = wide[31:0];
        trap = (c == 4'd3) && (wide[32] != wide[31]);
      end
      4'd4, 4'd8:  r = a << n;
      4'd5, 4'd9:  r = a >> n;
      4'd6, 4'd10: r = $unsigned($signed(a) >>> n);
      4'd7, 4'd11: r = dbl[31:0];
      4'd12:       r = 32'(lead_run(a, 1'b0));
      4'd13:       r = 32'(lead_run(a, 1'b1));
      default:     r = '0;
    endcase
  endfunction

  task automatic expect_out(input logic [3:0] c, input logic [31:0] a,
                            input logic [31:0] b, input logic [4:0] s);
    logic [31:0] r;
    logic        t;
    string       q;
    model(c, a, b, s, r, t);
    q = req_of(c);
    chk({q, " result"}, out_result, {{32{r[31]}}, r});
    chk({q, " trap"}, {63'd0, out_ovf_trap}, {63'd0, t});
    chk("R4 wr_en", {63'd0, out_wr_en}, {63'd0, !t});
    chk("R5 sign copy", out_result[63:32], {32{out_result[31]}});
  endtask

  task automatic run_op(input logic [3:0] c, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] s);
    @(negedge clk);
    in_valid = 1'b1; op = c; src_a = a; src_b = b; shamt = s; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 valid", {63'd0, out_valid}, 64'd1);
    expect_out(c, a, b, s);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h7fff_ffff;
      1: return 32'h8000_0000;
      2: return 32'h0000_0000;
      3: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // reset state R11
    #5;
    chk("R11 valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R11 ready in reset", {63'd0, in_ready}, 64'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid after reset", {63'd0, out_valid}, 64'd0);

    // directed corners
    run_op(4'd0, 32'h7fff_ffff, 32'h1, 5'd0);       // R1 wrap, no trap
    run_op(4'd1, 32'h8000_0000, 32'h1, 5'd0);       // R1
    run_op(4'd2, 32'h7fff_ffff, 32'h1, 5'd0);       // R2 overflow
    run_op(4'd2, 32'h8000_0000, 32'hffff_ffff, 5'd0); // R2 neg overflow
    run_op(4'd2, 32'h7fff_ffff, 32'hffff_ffff, 5'd0); // R2 mixed signs, none
    run_op(4'd3, 32'h8000_0000, 32'h1, 5'd0);       // R3 overflow
    run_op(4'd3, 32'h7fff_ffff, 32'hffff_ffff, 5'd0); // R3 overflow
    run_op(4'd3, 32'h1, 32'h1, 5'd0);               // R3 none
    run_op(4'd4, 32'h0000_8001, 32'h0, 5'd16);      // R6/R5 sign from shift
    run_op(4'd6, 32'h8000_0000, 32'h0, 5'd31);      // R6
    run_op(4'd9, 32'hf000_0000, 32'hffff_ffe4, 5'd0); // R6 only low 5 bits (4)
    run_op(4'd7, 32'h1234_5678, 32'h0, 5'd0);       // R7 zero amount
    run_op(4'd11, 32'h1234_5678, 32'h20, 5'd0);     // R7 reg amount 0 via low bits
    run_op(4'd7, 32'h0000_0001, 32'h0, 5'd1);       // R7
    run_op(4'd12, 32'h0, 32'h0, 5'd0);              // R8 all zero -> 32
    run_op(4'd13, 32'hffff_ffff, 32'h0, 5'd0);      // R8 all ones -> 32
    run_op(4'd12, 32'h0001_0000, 32'h0, 5'd0);      // R8
    run_op(4'd13, 32'hfff0_0000, 32'h0, 5'd0);      // R8
    run_op(4'd14, 32'hdead_beef, 32'h7, 5'd3);      // R9
    run_op(4'd15, 32'hffff_ffff, 32'h1, 5'd1);      // R9

    // back-pressure R10
    @(negedge clk);
    in_valid = 1'b1; op = 4'd13; src_a = 32'hf000_0000; src_b = '0; shamt = '0;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op = 4'd0; src_a = 32'd5; src_b = 32'd6;   // offered during stall
    for (int k = 0; k < 3; k++) begin
      chk("R10 stall valid", {63'd0, out_valid}, 64'd1);
      chk("R10 stall ready low", {63'd0, in_ready}, 64'd0);
      chk("R10 stall hold", out_result, 64'd4);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second op after stall", out_result, 64'd11);
    @(negedge clk);
    chk("R10 drained", {63'd0, out_valid}, 64'd0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c = 4'($urandom_range(0, 15));
      run_op(c, pick(), pick(), 5'($urandom_range(0, 31)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule